// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a small register-programmed SPI master that issues one short serial-flash command each time software sets its start bit. Software first loads a command word (opcode plus a 24-bit flash address) and a data word holding up to four outgoing bytes. It then writes a control word with a transmit byte count, a receive byte count, a clock divider and the start bit.

Once started, the engine pulls chip select low and shifts out the selected bytes, most significant bit first. It then clocks in up to four reply bytes, which land in the data word, and releases chip select. A busy flag covers the whole operation and a one-cycle done pulse marks its end. Only SPI clock mode 0 (clock idles low, data sampled on the rising edge) and a single target are supported. Transmit and receive never overlap.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every register reads 0, cs_n is 1 and sck is 0. The control word reads back the transmit count in bits [3:0], the receive count in bits [7:4], the divider in bits [15:12] and busy in bit 16, with bit 8 always 0. Counts are stored clamped: transmit to at most 8, receive to at most 4.
- R2: Writing address 0 (control) with bit 8 set and a nonzero clamped count starts an operation: busy reads 1 and cs_n stays low until the operation ends. A start with both counts zero does nothing.
- R3: SCK idles low. Each SCK half-period lasts DIV+1 system cycles. The first rising edge comes one half-period after cs_n falls, and cs_n rises one half-period after the last falling edge, so cs_n is low for (2N+1)(DIV+1) cycles for N bits.
- R4: Transmit byte k (k from 0) is the opcode (command bits [7:0]) for k=0. For k=1..3 it is the address, taken from command bits [31:24], then [23:16], then [15:8]. For k=4..7 it is data register lane k-4 (lane j is bits [8j+7:8j]). Each byte is sent most significant bit first and is valid at each SCK rising edge.
- R5: Receive bits are sampled from MISO at SCK rising edges, only after all transmit bits, most significant bit first. Reply byte j is stored into data lane j; lanes at or above the receive count keep their value.
- R6: Writes to the control, command (address 1) or data (address 2) registers while busy is 1 are ignored.
- R7: done is high for exactly one cycle per operation, in the cycle after busy falls.
- R8: An operation produces exactly 8×(transmit count + receive count) SCK rising edges.
- R9: MOSI is 0 while idle and during the receive phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 command, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |
| cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that chip select is high and the clock low while idle, that SCK only toggles with chip select low, that chip select rises with SCK low, that MOSI stays quiet when idle, that the command register is frozen during an operation, and that done follows the fall of busy. Only the bench scenarios can show the byte order on the wire, the placement of reply bytes in the data lanes, the exact edge counts and chip-select width for each divider, and the clamping of counts. To do so they sweep every transmit and receive count, including values past the clamps, under three divider settings against a target model.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] MAX_TX = 4'd8;
    localparam logic [CNT_W-1:0] MAX_RX = 4'd4;
    localparam int DIV_LSB = 12;
    localparam int BUSY_BIT = 16;
    localparam int START_BIT = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMD  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/spi_cmd_divider.sv
module spi_cmd_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div);
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             rx_we,
    input  logic [1:0]       rx_lane,
    input  logic [7:0]       rx_byte,
    output logic [31:0]      cmd,
    output logic [31:0]      data,
    output logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] rx_cnt,
    output logic [DIV_W-1:0] div,
    output logic             launch
);
    typedef struct packed {
        logic [31:0]      cmd;
        logic [31:0]      data;
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t r_d, r_q;
    logic [CNT_W-1:0] tx_cl, rx_cl;
    logic wdata_unused;

    assign wdata_unused = ^{reg_wdata[31:DIV_LSB+DIV_W], reg_wdata[DIV_LSB-1:START_BIT+1]};

    always_comb begin
        tx_cl = (reg_wdata[3:0] > MAX_TX) ? MAX_TX : reg_wdata[3:0];
        rx_cl = (reg_wdata[7:4] > MAX_RX) ? MAX_RX : reg_wdata[7:4];
        r_d    = r_q;
        launch = 1'b0;
        if (reg_wr && !busy) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    r_d.tx  = tx_cl;
                    r_d.rx  = rx_cl;
                    r_d.div = reg_wdata[DIV_LSB +: DIV_W];
                    launch  = reg_wdata[START_BIT] && ((tx_cl != '0) || (rx_cl != '0));
                end
                ADDR_CMD:  r_d.cmd  = reg_wdata;
                ADDR_DATA: r_d.data = reg_wdata;
                default: ;
            endcase
        end
        for (int l = 0; l < 4; l++) begin
            if (rx_we && (rx_lane == l[1:0])) r_d.data[8*l +: 8] = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[3:0]               = r_q.tx;
                reg_rdata[7:4]               = r_q.rx;
                reg_rdata[DIV_LSB +: DIV_W]  = r_q.div;
                reg_rdata[BUSY_BIT]          = busy;
            end
            ADDR_CMD:  reg_rdata = r_q.cmd;
            ADDR_DATA: reg_rdata = r_q.data;
            default:   reg_rdata = '0;
        endcase
    end

    assign cmd    = r_q.cmd;
    assign data   = r_q.data;
    assign tx_cnt = r_q.tx;
    assign rx_cnt = r_q.rx;
    assign div    = r_q.div;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             tick,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [31:0]      cmd,
    input  logic [31:0]      data,
    input  logic             miso,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic             rx_we,
    output logic [1:0]       rx_lane,
    output logic [7:0]       rx_byte
);
    typedef struct packed {
        eng_state_e state;
        logic       sck;
        logic       cs_n;
        logic [6:0] bit_idx;
        logic [6:0] rx_sh;
        logic       done;
    } eng_t;

    eng_t s_d, s_q;
    logic [3:0] byte_idx;
    logic [3:0] last_byte;
    logic       in_rx;
    logic       last_bit;
    logic [7:0] cur_tx;

    function automatic logic [7:0] pick_tx(input logic [3:0] idx,
                                           input logic [31:0] c,
                                           input logic [31:0] d);
        case (idx)
            4'd0:    pick_tx = c[7:0];
            4'd1:    pick_tx = c[31:24];
            4'd2:    pick_tx = c[23:16];
            4'd3:    pick_tx = c[15:8];
            4'd4:    pick_tx = d[7:0];
            4'd5:    pick_tx = d[15:8];
            4'd6:    pick_tx = d[23:16];
            4'd7:    pick_tx = d[31:24];
            default: pick_tx = 8'h00;
        endcase
    endfunction

    always_comb begin
        byte_idx  = s_q.bit_idx[6:3];
        last_byte = tx_cnt + rx_cnt - 4'd1;
        in_rx     = (byte_idx >= tx_cnt);
        last_bit  = (byte_idx == last_byte) && (s_q.bit_idx[2:0] == 3'd7);
        cur_tx    = pick_tx(byte_idx, cmd, data);
        rx_lane   = byte_idx[1:0] - tx_cnt[1:0];
        rx_byte   = {s_q.rx_sh, miso};
        rx_we     = 1'b0;

        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (launch) begin
                    s_d.state   = ST_SHIFT;
                    s_d.cs_n    = 1'b0;
                    s_d.sck     = 1'b0;
                    s_d.bit_idx = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!s_q.sck) begin
                        s_d.sck = 1'b1;
                        if (in_rx) begin
                            s_d.rx_sh = {s_q.rx_sh[5:0], miso};
                            rx_we     = (s_q.bit_idx[2:0] == 3'd7);
                        end
                    end else begin
                        s_d.sck = 1'b0;
                        if (last_bit) s_d.state   = ST_TAIL;
                        else          s_d.bit_idx = s_q.bit_idx + 7'd1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    s_d.state = ST_IDLE;
                    s_d.cs_n  = 1'b1;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.state   <= ST_IDLE;
            s_q.cs_n    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sck  = s_q.sck;
    assign cs_n = s_q.cs_n;
    assign busy = (s_q.state != ST_IDLE);
    assign done = s_q.done;
    assign mosi = (s_q.state == ST_SHIFT) && !in_rx && cur_tx[3'd7 - s_q.bit_idx[2:0]];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic        done
);
    logic [31:0]      cmd_w, data_w;
    logic [CNT_W-1:0] tx_w, rx_w;
    logic [DIV_W-1:0] div_w;
    logic             launch_w, busy_w, tick_w;
    logic             rx_we_w;
    logic [1:0]       rx_lane_w;
    logic [7:0]       rx_byte_w;

    spi_cmd_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .rx_we(rx_we_w), .rx_lane(rx_lane_w), .rx_byte(rx_byte_w),
        .cmd(cmd_w), .data(data_w), .tx_cnt(tx_w), .rx_cnt(rx_w), .div(div_w),
        .launch(launch_w)
    );

    spi_cmd_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(busy_w), .div(div_w), .tick(tick_w)
    );

    spi_cmd_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .launch(launch_w), .tick(tick_w),
        .tx_cnt(tx_w), .rx_cnt(rx_w), .cmd(cmd_w), .data(data_w), .miso(miso),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .busy(busy_w), .done(done),
        .rx_we(rx_we_w), .rx_lane(rx_lane_w), .rx_byte(rx_byte_w)
    );
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sck,
    input logic        cs_n,
    input logic        mosi,
    input logic        busy,
    input logic        done,
    input logic [31:0] cmd
);
    a_r2_cs_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sck));

    a_r3_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    a_r3_cs_rises_with_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sck);

    a_r6_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd));

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r9_mosi_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !mosi);
endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .busy(busy_w), .done(done), .cmd(cmd_w)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, mosi, cs_n, done;
    logic        miso = 1'b0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .done(done)
    );

    // target model
    int          tx_exp = 0;
    logic [31:0] reply = '0;
    int          rise_cnt = 0;
    int          mosi_bad = 0;
    logic [7:0]  got [8];
    int          cs_low = 0;
    int          done_cnt = 0;

    function automatic logic miso_for(int k);
        int j;
        if (k < tx_exp * 8) return 1'b0;
        j = k - tx_exp * 8;
        if (j >= 32) return 1'b0;
        return reply[(j / 8) * 8 + 7 - (j % 8)];
    endfunction

    always @(negedge cs_n) begin
        rise_cnt = 0;
        miso = miso_for(0);
    end

    always @(posedge sck) begin
        if (rise_cnt < tx_exp * 8) got[rise_cnt / 8][7 - (rise_cnt % 8)] = mosi;
        else if (mosi) mosi_bad++;
        rise_cnt++;
        miso = miso_for(rise_cnt);
    end

    always @(posedge clk) begin
        if (!cs_n) cs_low++;
        if (done) done_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] exp_tx(int k, logic [31:0] c, logic [31:0] d);
        case (k)
            0: return c[7:0];
            1: return c[31:24];
            2: return c[23:16];
            3: return c[15:8];
            default: return d[(k - 4) * 8 +: 8];
        endcase
    endfunction

    task automatic run_op(input int tx, input int rx, input int dv, input int idx);
        logic [31:0] c, d, v, expd;
        int txc, rxc, n, d0, c0, tmo;
        bit ok;
        txc = (tx > 8) ? 8 : tx;
        rxc = (rx > 4) ? 4 : rx;
        c = 32'h9E37_79B9 * (idx + 1);
        d = 32'h85EB_CA6B * (idx + 3);
        reply = 32'hC2B2_AE35 * (idx + 7);
        tx_exp = txc;
        mosi_bad = 0;
        for (int i = 0; i < 8; i++) got[i] = 8'h00;
        wr(2'd1, c);
        wr(2'd2, d);
        d0 = done_cnt;
        c0 = cs_low;
        wr(2'd0, (dv << 12) | (1 << 8) | (rx << 4) | tx);
        rd(2'd0, v);
        check(v[16] == 1'b1, "R2 busy after start", v, 32'h10000);
        // attempts while busy, all to be dropped
        wr(2'd1, ~c);
        wr(2'd2, ~d);
        wr(2'd0, 32'h0000_0111);
        tmo = 0;
        while (done_cnt == d0 && tmo < 2000) begin
            @(negedge clk);
            tmo++;
        end
        repeat (2) @(negedge clk);
        n = 8 * (txc + rxc);
        check(rise_cnt == n, "R8 sck rising edges", rise_cnt, n);
        check(cs_low - c0 == (2 * n + 1) * (dv + 1), "R3 cs_n low cycles", cs_low - c0, (2 * n + 1) * (dv + 1));
        check(done_cnt - d0 == 1, "R7 done pulses", done_cnt - d0, 1);
        ok = 1'b1;
        for (int k = 0; k < txc; k++) if (got[k] !== exp_tx(k, c, d)) ok = 1'b0;
        check(ok, "R4 transmit bytes", {got[0], got[1], got[2], got[3]}, {exp_tx(0, c, d), exp_tx(1, c, d), exp_tx(2, c, d), exp_tx(3, c, d)});
        check(mosi_bad == 0, "R9 mosi low in receive phase", mosi_bad, 0);
        expd = d;
        for (int l = 0; l < rxc; l++) expd[l * 8 +: 8] = reply[l * 8 +: 8];
        rd(2'd2, v);
        check(v == expd, "R5 R6 data register after op", v, expd);
        rd(2'd1, v);
        check(v == c, "R6 command kept while busy", v, c);
        rd(2'd0, v);
        check(v == ((dv << 12) | (rxc << 4) | txc), "R6 control kept while busy", v, (dv << 12) | (rxc << 4) | txc);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int idx, d0;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R1 reset pins", {cs_n, sck, mosi}, 3'b100);
        rd(2'd0, v); check(v == 0, "R1 reset control", v, 0);
        rd(2'd1, v); check(v == 0, "R1 reset command", v, 0);
        rd(2'd2, v); check(v == 0, "R1 reset data", v, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // clamp and field layout, no start
        wr(2'd0, 32'h0000_209C);
        rd(2'd0, v); check(v == 32'h0000_2048, "R1 control clamp and layout", v, 32'h0000_2048);
        check(cs_n == 1'b1, "R1 no start without bit 8", cs_n, 1);
        // zero-count start
        d0 = done_cnt;
        wr(2'd0, 32'h0000_0100);
        repeat (10) @(negedge clk);
        check(done_cnt == d0 && cs_n == 1'b1, "R2 zero-count start ignored", done_cnt - d0, 0);
        idx = 0;
        for (int dv = 0; dv < 3; dv++) begin
            for (int tx = 0; tx < 10; tx++) begin
                for (int rx = 0; rx < 6; rx++) begin
                    if (tx != 0 || rx != 0) begin
                        run_op(tx, rx, dv, idx);
                        idx++;
                    end
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule